// File: doc/BRIEF.md
# Ordered Store Queue with Fence Control

This block sits between the memory-access port of a simple in-order core and one data memory port. Stores from the core are placed in a small in-order queue and written to memory later, one per memory handshake, once the core has declared them non-speculative with a retire pulse. Loads look into the queue first. A load whose word address matches a queued store gets the data of the youngest such store straight from the queue. A load with no match reads memory at once, even while older stores are still waiting. A later load can therefore overtake an earlier store.

Three ordering operations shape that behaviour. A full fence is held at the core port until every queued store has reached memory. A load-only fence is taken at once and leaves the queue untouched. A release store enters the queue like any store and reaches memory only after all older stores. An empty flag reports the drained, idle state.

Top module: `store_buf_top`

## Requirements
- R1: An accepted store (req_op 1) or release store (req_op 2) is queued. No memory write occurs for it before it has been retired.
- R2: A load (req_op 0) whose word address equals that of a queued store returns that store's data and issues no memory read. For a hit, rsp_valid pulses in the cycle after acceptance.
- R3: When several queued stores share the load's exact word address, the youngest one supplies the data.
- R4: A load that matches no queued store reads memory even while older stores are still queued, and returns the memory value.
- R5: Stores are written to memory in program order from the queue head, one per accepted memory handshake (mem_req_we = 1). Each retire_i pulse marks the oldest unretired queued store. A request that is not accepted holds valid, address, data and direction stable.
- R6: A full fence (req_op 3) is not accepted while any store is queued. Once it is accepted the queue is empty.
- R7: A load-only fence (req_op 4) is accepted without waiting for the queue, and stores that are still queued stay queued.
- R8: A release store reaches memory only after every older queued store.
- R9: The queue holds 8 stores. A store request is stalled while the queue is full, and loads are still served.
- R10: A retire pulse given while no queued store is unretired has no effect. A store pushed afterwards still waits for a retire pulse of its own.
- R11: sq_empty is high exactly when the queue is empty and no load is outstanding. No memory request is made while it is high.
- R12: After reset the queue is empty, sq_empty and req_ready are high, and neither rsp_valid nor mem_req_valid is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Core request accepted this cycle |
| req_op | input | 3 | 0 load, 1 store, 2 release store, 3 full fence, 4 load-only fence |
| req_addr | input | 32 | Word address |
| req_wdata | input | 32 | Store data |
| retire_i | input | 1 | Marks the oldest unretired queued store retired |
| rsp_valid | output | 1 | Load data valid (one-cycle pulse) |
| rsp_data | output | 32 | Load data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 write (commit), 0 read |
| mem_req_addr | output | 32 | Memory word address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| sq_empty | output | 1 | Queue drained and no load outstanding |

## Verification
The bench fills the queue with address patterns that repeat across a small set of words, so that several entries often match one load. If the design picked the oldest match instead of the youngest, the returned values would be wrong. If it went to memory on a hit, a stale value would come back and an extra read would be counted. Each load that misses is checked for a memory read while unretired stores remain queued, so a design that drains before every load is caught. Each commit is compared against the program order of the pushes and against the number of retires, which exposes early, reordered or speculative writes. The bench also holds a full fence against unretired stores and adds surplus retire pulses, so a fence that slips through early or a retire counter that over-counts shows up as an early write or a non-empty queue.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
    parameter int unsigned AW    = 32;
    parameter int unsigned DW    = 32;
    parameter int unsigned DEPTH = 8;   // must be a power of two
    localparam int unsigned PW   = $clog2(DEPTH);
    localparam int unsigned CW   = PW + 1;

    typedef enum logic [2:0] {
        OP_LOAD       = 3'd0,
        OP_STORE      = 3'd1,
        OP_STORE_REL  = 3'd2,
        OP_FENCE_FULL = 3'd3,
        OP_FENCE_LD   = 3'd4
    } op_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } entry_t;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_ISSUE = 2'd1,
        LD_WAIT  = 2'd2
    } ld_state_e;

    function automatic logic is_store(op_e op);
        return (op == OP_STORE) || (op == OP_STORE_REL);
    endfunction
endpackage

// File: rtl/stbuf_ring.sv
module stbuf_ring
    import stbuf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  entry_t        push_entry,
    input  logic          pop,
    output entry_t        head_entry,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    input  logic [AW-1:0] lookup_addr,
    output logic          hit,
    output logic [DW-1:0] hit_data
);
    entry_t        slots [DEPTH];
    logic [PW-1:0] head_q, tail_q, idx;
    logic [CW-1:0] cnt_q;
    logic [DEPTH-1:0] slot_match;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) tail_q <= tail_q + 1'b1;
            if (pop)  head_q <= head_q + 1'b1;
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) slots[tail_q] <= push_entry;
    end

    // per-slot compare, valid only inside the occupied window
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic [PW-1:0] age;
        assign age = PW'(g) - head_q;
        assign slot_match[g] = ({1'b0, age} < cnt_q) && (slots[g].addr == lookup_addr);
    end

    // walk oldest to youngest; the last match wins
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        idx      = '0;
        for (int i = 0; i < DEPTH; i++) begin
            idx = head_q + PW'(i);
            if (slot_match[idx]) begin
                hit      = 1'b1;
                hit_data = slots[idx].data;
            end
        end
    end

    assign head_entry = slots[head_q];
    assign count      = cnt_q;
    assign full       = (cnt_q == CW'(DEPTH));
    assign empty      = (cnt_q == '0);
endmodule

// File: rtl/stbuf_retire.sv
module stbuf_retire
    import stbuf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          retire_i,
    input  logic [CW-1:0] count,
    input  logic          commit_fire,
    output logic          can_commit
);
    logic [CW-1:0] ret_q;
    logic          advance;

    // retired entries are a contiguous run starting at the head
    assign advance = retire_i && (ret_q < count);

    always_ff @(posedge clk) begin
        if (rst) ret_q <= '0;
        else     ret_q <= ret_q + CW'(advance) - CW'(commit_fire);
    end

    assign can_commit = (ret_q != '0);
endmodule

// File: rtl/stbuf_load_fsm.sv
module stbuf_load_fsm
    import stbuf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          hit_go,
    input  logic [DW-1:0] hit_data,
    input  logic          miss_go,
    input  logic [AW-1:0] miss_addr,
    input  logic          mem_ready,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          rd_valid,
    output logic [AW-1:0] rd_addr,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data
);
    ld_state_e     state_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= LD_IDLE;
            addr_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                LD_IDLE: begin
                    if (hit_go) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= hit_data;
                    end else if (miss_go) begin
                        addr_q  <= miss_addr;
                        state_q <= LD_ISSUE;
                    end
                end
                LD_ISSUE: if (mem_ready) state_q <= LD_WAIT;
                LD_WAIT: begin
                    if (mem_rvalid) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= mem_rdata;
                        state_q   <= LD_IDLE;
                    end
                end
                default: state_q <= LD_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != LD_IDLE);
    assign rd_valid = (state_q == LD_ISSUE);
    assign rd_addr  = addr_q;
endmodule

// File: rtl/store_buf_top.sv
module store_buf_top
    import stbuf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          retire_i,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_we,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_rdata,
    output logic          sq_empty
);
    op_e           op;
    logic          is_ld, is_st, is_ffull;
    logic [CW-1:0] q_count;
    logic          q_full, q_empty, hit;
    logic [DW-1:0] hit_data;
    entry_t        head_e, new_e;
    logic          busy, rd_valid;
    logic [AW-1:0] rd_addr;
    logic          can_commit, commit_valid, commit_fire, ld_block;
    logic          acc, push, hit_go, miss_go;

    assign op       = op_e'(req_op);
    assign is_ld    = (op == OP_LOAD);
    assign is_st    = is_store(op);
    assign is_ffull = (op == OP_FENCE_FULL);

    // commits use the memory port only while no load owns it
    assign commit_valid = !busy && can_commit;
    assign commit_fire  = commit_valid && mem_req_ready;
    assign ld_block     = commit_valid && !mem_req_ready;

    always_comb begin
        req_ready = !busy;
        if (is_st)         req_ready = !busy && !q_full;
        else if (is_ffull) req_ready = !busy && q_empty;
        else if (is_ld)    req_ready = !busy && !ld_block;
    end

    assign acc     = req_valid && req_ready;
    assign push    = acc && is_st;
    assign hit_go  = acc && is_ld && hit;
    assign miss_go = acc && is_ld && !hit;
    assign new_e   = '{addr: req_addr, data: req_wdata};

    stbuf_ring u_ring (
        .clk(clk), .rst(rst),
        .push(push), .push_entry(new_e), .pop(commit_fire),
        .head_entry(head_e), .count(q_count), .full(q_full), .empty(q_empty),
        .lookup_addr(req_addr), .hit(hit), .hit_data(hit_data)
    );

    stbuf_retire u_ret (
        .clk(clk), .rst(rst), .retire_i(retire_i), .count(q_count),
        .commit_fire(commit_fire), .can_commit(can_commit)
    );

    stbuf_load_fsm u_ld (
        .clk(clk), .rst(rst),
        .hit_go(hit_go), .hit_data(hit_data),
        .miss_go(miss_go), .miss_addr(req_addr),
        .mem_ready(mem_req_ready), .mem_rvalid(mem_rsp_valid), .mem_rdata(mem_rsp_rdata),
        .busy(busy), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    assign mem_req_valid = rd_valid || commit_valid;
    assign mem_req_we    = !rd_valid;
    assign mem_req_addr  = rd_valid ? rd_addr : head_e.addr;
    assign mem_req_wdata = head_e.data;
    assign sq_empty      = q_empty && !busy;
endmodule

// File: rtl/stbuf_checker.sv
module stbuf_checker
    import stbuf_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic [2:0]    req_op,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic          mem_req_we,
    input logic [AW-1:0] mem_req_addr,
    input logic [DW-1:0] mem_req_wdata,
    input logic          sq_empty,
    input logic [CW-1:0] q_count
);
    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        q_count <= CW'(DEPTH));

    // R6
    fence_drained_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_op == 3'(OP_FENCE_FULL)) |-> (q_count == '0));

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr) &&
             (!mem_req_we || $stable(mem_req_wdata))));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        sq_empty |-> !mem_req_valid);
endmodule

bind store_buf_top stbuf_checker u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .sq_empty(sq_empty), .q_count(q_count)
);

// File: tb/store_buf_top_tb.sv
module store_buf_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_ready;
    logic [2:0]  req_op = 3'd0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        retire_i = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        mem_req_valid, mem_req_ready, mem_req_we;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_rdata;
    logic        sq_empty;

    always #2 clk = ~clk;

    store_buf_top u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .retire_i(retire_i), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .sq_empty(sq_empty)
    );

    int checks = 0, fails = 0;
    logic [31:0] mem_model [16];
    logic [31:0] exp_mem   [16];
    logic [31:0] exp_wa [128];
    logic [31:0] exp_wd [128];
    int push_n = 0, ret_total = 0, wr_idx = 0, rd_count = 0;
    logic rd_pend = 1'b0;
    logic [31:0] rd_dat = '0;
    int cyc = 0;
    bit ready_mode = 1'b0;

    assign mem_req_ready = ready_mode ? (cyc % 3 != 0) : 1'b1;
    assign mem_rsp_valid = rd_pend;
    assign mem_rsp_rdata = rd_dat;

    // memory model; every commit is compared with program order (R5, R8, R1)
    always @(posedge clk) begin
        cyc     <= cyc + 1;
        rd_pend <= 1'b0;
        if (!rst && mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                checks++;
                if (wr_idx >= ret_total || wr_idx >= push_n) begin
                    fails++;
                    $display("FAIL R1 commit %0d before retire: actual addr=%0h expected retired count>%0d",
                             wr_idx, mem_req_addr, wr_idx);
                end else if (mem_req_addr != exp_wa[wr_idx] || mem_req_wdata != exp_wd[wr_idx]) begin
                    fails++;
                    $display("FAIL R5/R8 commit %0d: actual %0h:%0h expected %0h:%0h", wr_idx,
                             mem_req_addr, mem_req_wdata, exp_wa[wr_idx], exp_wd[wr_idx]);
                end
                mem_model[mem_req_addr[3:0]] = mem_req_wdata;
                wr_idx++;
            end else begin
                rd_count++;
                rd_pend <= 1'b1;
                rd_dat  <= mem_model[mem_req_addr[3:0]];
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] d, output bit ok);
        int n = 0;
        ok = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        #1;
        while (!req_ready && n < 300) begin
            @(negedge clk); #1; n++;
        end
        if (req_ready) begin
            ok = 1'b1;
            @(posedge clk);
            if (op == 3'd1 || op == 3'd2) begin
                exp_wa[push_n] = a; exp_wd[push_n] = d;
                exp_mem[a[3:0]] = d;
                push_n++;
            end
        end
        #1;
        req_valid = 1'b0;
    endtask

    task automatic st(input logic [31:0] a, input logic [31:0] d, input bit rel);
        bit ok;
        do_op(rel ? 3'd2 : 3'd1, a, d, ok);
        if (!ok) begin
            checks++; fails++;
            $display("FAIL R9 store not accepted: actual=0 expected=1");
        end
    endtask

    task automatic load(input logic [31:0] a, output logic [31:0] v);
        bit ok;
        int n = 0;
        v = 32'hDEAD_BEEF;
        do_op(3'd0, a, 32'h0, ok);
        while (ok && n < 100) begin
            @(negedge clk);
            if (rsp_valid) begin v = rsp_data; break; end
            n++;
        end
    endtask

    task automatic retire();
        @(negedge clk);
        retire_i = 1'b1;
        if (ret_total < push_n) ret_total++;
        @(negedge clk);
        retire_i = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        @(negedge clk);
        while (!sq_empty && n < 300) begin @(negedge clk); n++; end
    endtask

    function automatic bit pending(input logic [31:0] a);
        for (int k = wr_idx; k < push_n; k++)
            if (exp_wa[k] == a) return 1'b1;
        return 1'b0;
    endfunction

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: actual=timeout expected=finish");
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        join_none
    end

    initial begin
        logic [31:0] v;
        int rd0, w0, n;
        bit ok;
        for (int i = 0; i < 16; i++) begin
            mem_model[i] = 32'hA000_0000 + i;
            exp_mem[i]   = 32'hA000_0000 + i;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(sq_empty == 1'b1, "R12 empty", {31'd0, sq_empty}, 1);
        check(req_ready == 1'b1, "R12 ready", {31'd0, req_ready}, 1);
        check(!mem_req_valid && !rsp_valid, "R12 idle outputs", {30'd0, mem_req_valid, rsp_valid}, 0);

        // R1: queued stores stay out of memory until retired
        st(1, 32'h11, 0); st(2, 32'h22, 0); st(1, 32'h33, 0);
        repeat (10) @(negedge clk);
        check(wr_idx == 0, "R1 no early write", wr_idx, 0);
        check(sq_empty == 1'b0, "R11 not empty", {31'd0, sq_empty}, 0);

        // R2 forward, R3 youngest wins
        rd0 = rd_count;
        load(2, v);
        check(v == 32'h22, "R2 forward", v, 32'h22);
        load(1, v);
        check(v == 32'h33, "R3 youngest", v, 32'h33);
        check(rd_count == rd0, "R2 no read on hit", rd_count, rd0);
        check(mem_model[1] == 32'hA000_0001, "R2 memory still old", mem_model[1], 32'hA000_0001);

        // R4 miss passes the queued stores
        rd0 = rd_count;
        load(7, v);
        check(v == 32'hA000_0007, "R4 miss data", v, 32'hA000_0007);
        check(rd_count == rd0 + 1 && wr_idx == 0, "R4 read while stores queued", rd_count, rd0 + 1);

        // R7 load-only fence does not drain
        do_op(3'd4, 0, 0, ok);
        check(ok, "R7 accepted", {31'd0, ok}, 1);
        check(sq_empty == 1'b0 && wr_idx == 0, "R7 queue kept", wr_idx, 0);
        load(9, v);
        check(v == 32'hA000_0009 && wr_idx == 0, "R7 later load passes", v, 32'hA000_0009);

        // R6 full fence waits for drain
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd3; req_addr = 0; req_wdata = 0;
        ok = 1'b1;
        repeat (6) begin @(negedge clk); #1; if (req_ready) ok = 1'b0; end
        check(ok, "R6 fence held", {31'd0, ok}, 1);
        retire(); retire(); retire();
        n = 0;
        @(negedge clk); #1;
        while (!req_ready && n < 300) begin @(negedge clk); #1; n++; end
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        check(sq_empty == 1'b1 && wr_idx == 3, "R6 drained after fence", wr_idx, 3);
        check(mem_model[1] == 32'h33 && mem_model[2] == 32'h22, "R6 memory updated", mem_model[1], 32'h33);

        // R8 release store ordered after older stores
        st(4, 32'h44, 0); st(5, 32'h55, 0); st(6, 32'h66, 1); st(4, 32'h77, 0);
        retire(); retire(); retire(); retire();
        drain();
        check(wr_idx == push_n, "R8 all committed", wr_idx, push_n);
        check(mem_model[6] == 32'h66 && mem_model[4] == 32'h77, "R8 final memory", mem_model[4], 32'h77);

        // R10 surplus retires ignored
        retire(); retire(); retire();
        w0 = wr_idx;
        st(8, 32'h88, 0);
        repeat (15) @(negedge clk);
        check(wr_idx == w0 && sq_empty == 1'b0, "R10 store still waits", wr_idx, w0);
        retire();
        drain();
        check(mem_model[8] == 32'h88, "R10 commit after own retire", mem_model[8], 32'h88);

        // sweep: full queue with repeating addresses, stalls on the memory side
        for (int r = 0; r < 6; r++) begin
            ready_mode = r[0];
            for (int i = 0; i < 8; i++)
                st((i * (r + 1) + r) % 4, 32'hC000_0000 + 32'h100 * r + i, (i % 3) == 2);
            if (r == 0) begin
                @(negedge clk);
                req_valid = 1'b1; req_op = 3'd1; req_addr = 3; req_wdata = 32'hFFFF;
                ok = 1'b1;
                repeat (3) begin #1; if (req_ready) ok = 1'b0; @(negedge clk); end
                req_valid = 1'b0;
                check(ok, "R9 store stalled when full", {31'd0, ok}, 1);
            end
            for (int a = 0; a < 6; a++) begin
                bit pend;
                pend = pending(a);
                rd0 = rd_count;
                load(a, v);
                check(v == exp_mem[a], "R3 sweep load", v, exp_mem[a]);
                check(pend ? (rd_count == rd0) : (rd_count == rd0 + 1), "R2/R4 read count",
                      rd_count - rd0, pend ? 0 : 1);
            end
            retire(); retire(); retire(); retire();
            for (int a = 0; a < 4; a++) begin
                load(a, v);
                check(v == exp_mem[a], "R9 load while committing", v, exp_mem[a]);
            end
            retire(); retire(); retire(); retire();
            drain();
            check(sq_empty == 1'b1 && wr_idx == push_n, "R11 drained", wr_idx, push_n);
            for (int a = 0; a < 6; a++)
                check(mem_model[a] == exp_mem[a], "R5 memory image", mem_model[a], exp_mem[a]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule